// File: doc/BRIEF.md
# Parity-Checked One-Bit Adder/Subtractor Cell

This block is a single-bit arithmetic cell that either adds or subtracts, selected by a mode pin. It is built only from three kinds of parity-preserving reversible gate. A double-fanout gate copies one input onto two XOR paths. A controlled-swap gate exchanges two lines when its control is high. A modified four-line gate produces an XOR, an AND-into-XOR and an AND-NOT-into-XOR term. The cell uses one double-fanout gate, one controlled-swap gate and two four-line gates. Four of their inputs are tied to constant zero.

Every gate instance has its own parity monitor. The monitor compares the XOR of the gate's inputs with the XOR of its outputs. The cell ORs all four mismatch indications into a single fault output. A fault-free cell therefore always holds that output low, and a corrupted gate raises it for some input pattern. Unused gate outputs are exposed on a garbage bus so that every line of every gate stays observable.

The cell is purely combinational, with no clock and no state. It is meant to be chained bit by bit into ripple or skip-style adder/subtractor rows. The carry/borrow output of one cell feeds the carry/borrow input of the next, and the propagate output feeds block-skip logic. The single-bit data path carries no flow control; callers stage it between their own registers.

Top module: `pp_fas_cell`

## Requirements
- R1: In both modes `sum_o` equals `a_i xor b_i xor cin_i`.
- R2: With `mode_i` = 0 (add), `cout_o` equals `a_i·b_i + cin_i·(a_i xor b_i)`.
- R3: With `mode_i` = 1 (subtract, computing a_i − b_i − cin_i), `cout_o` is the borrow `~a_i·b_i + cin_i·(a_i xnor b_i)`.
- R4: `prop_o` equals `(a_i xor mode_i) xor b_i`, so a carry/borrow input passes straight to `cout_o` whenever `prop_o` is 1.
- R5: `fault_o` is 0 for every combination of inputs, because each gate's input parity equals its output parity.
- R6: The garbage bus carries, by bit index: [0] = a_i, [1] = a_i xor mode_i, [2] = (a_i xor mode_i)·~b_i, [3] = a_i xor b_i, [4] = (a_i xor b_i)·cin_i, [5] = (a_i xor b_i)·~cin_i, [6] = ~prop_o·cin_i.
- R7: The outputs depend only on the present inputs: with the inputs held, the outputs stay unchanged across clock periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 1 | Operand bit A (minuend in subtract mode) |
| b_i | input | 1 | Operand bit B (subtrahend in subtract mode) |
| cin_i | input | 1 | Carry input (add) or borrow input (subtract) |
| mode_i | input | 1 | 0 = add, 1 = subtract |
| sum_o | output | 1 | Sum or difference bit |
| cout_o | output | 1 | Carry output (add) or borrow output (subtract) |
| prop_o | output | 1 | Propagate: (A xor mode) xor B |
| garb_o | output | 7 | Unused gate outputs, layout per R6 |
| fault_o | output | 1 | OR of all per-gate parity mismatches |

## Verification
Whenever the inputs are known, the embedded assertions check the arithmetic identities at the ports. These are the sum, the carry in add mode, the borrow in subtract mode and the propagate value. They also check that the fault output stays low. Only the bench's scenarios show the following: the exact garbage bit layout, and full coverage of all sixteen input combinations in both modes. They also show that the outputs hold steady while the inputs are held. The bench combines an exhaustive sweep with seeded random patterns and some directed carry-chain corners.

// File: rtl/pp_fas_pkg.sv
package pp_fas_pkg;
  localparam int GARB_W  = 7;
  localparam int NGATES  = 4;
  localparam int F2G_W   = 3;
  localparam int SWAP_W  = 3;
  localparam int MIG_W   = 4;

  typedef enum logic { MODE_ADD = 1'b0, MODE_SUB = 1'b1 } fas_mode_e;

  typedef enum int unsigned {
    GATE_FAN = 0, GATE_MIG_GEN = 1, GATE_MIG_SUM = 2, GATE_SWAP = 3
  } gate_idx_e;
endpackage

// File: rtl/pp_par_chk.sv
module pp_par_chk #(
  parameter int LINES = 3
) (
  input  logic [LINES-1:0] in_v,
  input  logic [LINES-1:0] out_v,
  output logic             mismatch_o
);
  logic in_par, out_par;
  always_comb begin
    in_par  = ^in_v;
    out_par = ^out_v;
    mismatch_o = in_par ^ out_par;
  end
endmodule

// File: rtl/pp_gate_fan.sv
module pp_gate_fan (
  input  logic x_i, y_i, z_i,
  output logic p_o, q_o, r_o,
  output logic fault_o
);
  localparam int W = pp_fas_pkg::F2G_W;
  always_comb begin
    p_o = x_i;
    q_o = x_i ^ y_i;
    r_o = x_i ^ z_i;
  end
  pp_par_chk #(.LINES(W)) chk_i (
    .in_v({x_i, y_i, z_i}), .out_v({p_o, q_o, r_o}), .mismatch_o(fault_o)
  );
endmodule

// File: rtl/pp_gate_swap.sv
module pp_gate_swap (
  input  logic x_i, y_i, z_i,
  output logic p_o, q_o, r_o,
  output logic fault_o
);
  localparam int W = pp_fas_pkg::SWAP_W;
  always_comb begin
    p_o = x_i;
    q_o = (~x_i & y_i) ^ (x_i & z_i);
    r_o = (~x_i & z_i) ^ (x_i & y_i);
  end
  pp_par_chk #(.LINES(W)) chk_i (
    .in_v({x_i, y_i, z_i}), .out_v({p_o, q_o, r_o}), .mismatch_o(fault_o)
  );
endmodule

// File: rtl/pp_gate_mig.sv
module pp_gate_mig (
  input  logic w_i, x_i, y_i, z_i,
  output logic p_o, q_o, r_o, s_o,
  output logic fault_o
);
  localparam int W = pp_fas_pkg::MIG_W;
  always_comb begin
    p_o = w_i;
    q_o = w_i ^ x_i;
    r_o = (w_i & x_i) ^ y_i;
    s_o = (w_i & ~x_i) ^ z_i;
  end
  pp_par_chk #(.LINES(W)) chk_i (
    .in_v({w_i, x_i, y_i, z_i}), .out_v({p_o, q_o, r_o, s_o}), .mismatch_o(fault_o)
  );
endmodule

// File: rtl/pp_fas_cell.sv
module pp_fas_cell
  import pp_fas_pkg::*;
(
  input  logic              a_i,
  input  logic              b_i,
  input  logic              cin_i,
  input  logic              mode_i,
  output logic              sum_o,
  output logic              cout_o,
  output logic              prop_o,
  output logic [GARB_W-1:0] garb_o,
  output logic              fault_o
);
  localparam logic TIE0 = 1'b0;

  logic [NGATES-1:0] gate_fault;
  logic a_cp, a_x, a_xor_b;
  logic g_ax, g_pp, g_gen, g_axnb;
  logic m_h, m_hc, m_hnc;
  logic s_pp, s_sel;

  // fan gate: copies A onto the mode path and the B path
  pp_gate_fan fan_i (
    .x_i(a_i), .y_i(mode_i), .z_i(b_i),
    .p_o(a_cp), .q_o(a_x), .r_o(a_xor_b),
    .fault_o(gate_fault[GATE_FAN])
  );

  // generate gate: mode-adjusted propagate and generate terms
  pp_gate_mig mig_gen_i (
    .w_i(a_x), .x_i(b_i), .y_i(TIE0), .z_i(TIE0),
    .p_o(g_ax), .q_o(g_pp), .r_o(g_gen), .s_o(g_axnb),
    .fault_o(gate_fault[GATE_MIG_GEN])
  );

  // sum gate: A xor B xor carry-in
  pp_gate_mig mig_sum_i (
    .w_i(a_xor_b), .x_i(cin_i), .y_i(TIE0), .z_i(TIE0),
    .p_o(m_h), .q_o(sum_o), .r_o(m_hc), .s_o(m_hnc),
    .fault_o(gate_fault[GATE_MIG_SUM])
  );

  // swap gate: propagate selects carry-in, otherwise generate
  pp_gate_swap swap_i (
    .x_i(g_pp), .y_i(g_gen), .z_i(cin_i),
    .p_o(s_pp), .q_o(cout_o), .r_o(s_sel),
    .fault_o(gate_fault[GATE_SWAP])
  );

  always_comb begin
    prop_o  = s_pp;
    fault_o = |gate_fault;
    garb_o  = {s_sel, m_hnc, m_hc, m_h, g_axnb, g_ax, a_cp};
  end

  always_comb begin
    if (!$isunknown({a_i, b_i, cin_i, mode_i})) begin
      a_r1_sum_bit: assert (sum_o == (a_i ^ b_i ^ cin_i))
        else $error("R1 sum mismatch");
      if (mode_i == MODE_ADD) begin
        a_r2_carry_out: assert (cout_o == ((a_i & b_i) | (cin_i & (a_i ^ b_i))))
          else $error("R2 carry mismatch");
      end else begin
        a_r3_borrow_out: assert (cout_o == ((~a_i & b_i) | (cin_i & ~(a_i ^ b_i))))
          else $error("R3 borrow mismatch");
      end
      a_r4_prop_skip: assert (!prop_o || (cout_o == cin_i))
        else $error("R4 propagate does not pass carry");
      a_r5_no_fault: assert (fault_o == 1'b0)
        else $error("R5 parity fault raised");
    end
  end
endmodule

// File: tb/pp_fas_cell_tb_top.sv
`timescale 1ns/1ps
module pp_fas_cell_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a, b, cin, mode;
  logic sum, cout, prop, fault;
  logic [6:0] garb;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pp_fas_cell dut_i (
    .a_i(a), .b_i(b), .cin_i(cin), .mode_i(mode),
    .sum_o(sum), .cout_o(cout), .prop_o(prop), .garb_o(garb), .fault_o(fault)
  );

  function automatic logic exp_sum(logic x, logic y, logic c);
    return x ^ y ^ c;
  endfunction
  function automatic logic exp_cout(logic x, logic y, logic c, logic m);
    if (!m) return (x & y) | (c & (x ^ y));
    return (~x & y) | (c & ~(x ^ y));
  endfunction
  function automatic logic exp_prop(logic x, logic y, logic m);
    return (x ^ m) ^ y;
  endfunction
  function automatic logic [6:0] exp_garb(logic x, logic y, logic c, logic m);
    logic pp;
    pp = (x ^ m) ^ y;
    return {~pp & c, (x ^ y) & ~c, (x ^ y) & c, x ^ y, (x ^ m) & ~y, x ^ m, x};
  endfunction

  task automatic chk(string req, logic [6:0] act, logic [6:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s a=%0b b=%0b cin=%0b mode=%0b actual=%0h expected=%0h",
               req, a, b, cin, mode, act, exp);
    end
  endtask

  task automatic apply_and_check(logic x, logic y, logic c, logic m);
    @(posedge clk);
    a = x; b = y; cin = c; mode = m;
    @(negedge clk);
    chk("R1", {6'd0, sum}, {6'd0, exp_sum(x, y, c)});
    if (!m) chk("R2", {6'd0, cout}, {6'd0, exp_cout(x, y, c, m)});
    else    chk("R3", {6'd0, cout}, {6'd0, exp_cout(x, y, c, m)});
    chk("R4", {6'd0, prop}, {6'd0, exp_prop(x, y, m)});
    chk("R5", {6'd0, fault}, 7'd0);
    chk("R6", garb, exp_garb(x, y, c, m));
  endtask

  initial begin
    int unsigned seed;
    logic [3:0] v;
    logic [10:0] snap;
    a = 0; b = 0; cin = 0; mode = 0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // initial state with all inputs zero
    chk("R1", {6'd0, sum}, 7'd0);
    chk("R2", {6'd0, cout}, 7'd0);
    chk("R5", {6'd0, fault}, 7'd0);
    // exhaustive sweep of all 16 patterns
    for (int i = 0; i < 16; i++) begin
      v = 4'(i);
      apply_and_check(v[3], v[2], v[1], v[0]);
    end
    // directed corners: full propagate chains and borrow out of zero
    apply_and_check(1, 0, 1, 0);
    apply_and_check(0, 0, 1, 1);
    apply_and_check(1, 1, 1, 1);
    apply_and_check(0, 1, 0, 1);
    // seeded random patterns
    seed = 32'h5EED_1234;
    void'($urandom(seed));
    for (int i = 0; i < 40; i++) begin
      v = 4'($urandom());
      apply_and_check(v[3], v[2], v[1], v[0]);
    end
    // R7: held inputs give unchanged outputs across periods
    apply_and_check(1, 0, 1, 1);
    snap = {sum, cout, prop, fault, garb};
    repeat (4) @(negedge clk);
    chk("R7", snap[6:0], garb);
    chk("R7", {3'd0, snap[10:7]}, {3'd0, sum, cout, prop, fault});
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule